// File: doc/BRIEF.md
# Readout Fragment Framing Checker

This block sits between a readout link's receive FIFO and a DMA engine. It pulls 64-bit words from the FIFO, each with a flag that marks it as a control word or a data word. It checks the shape of each event fragment as the words stream through. A fragment opens with a header control word, carries any number of payload data words, and closes with a trailer control word.

While the words pass, the block counts them and updates a CRC-16 word by word, so the data is never read twice. When the trailer arrives, the count and the CRC are compared with the values the trailer carries. The block then reports the fragment's trigger number, bunch-crossing number and source number, along with three error flags. Every accepted word goes out unchanged to the DMA side, marked as start or end of fragment. Words that break the framing are dropped and raise a one-cycle framing pulse.

Top module: `frag_rx`

## Requirements
- R1: `in_read_o` is high exactly when `in_valid_i` is high and the output slot is free (`out_valid_o` low or `out_ready_i` high). A word that is read and forwarded appears on `out_data_o`, unchanged, from the next cycle. Forwarded words keep their arrival order, and none is dropped or duplicated.
- R2: While `out_valid_o` is high and `out_ready_i` is low, the output word and its markers hold steady and `out_valid_o` stays high.
- R3: A control word whose bits 63:60 equal 4'h5 is a header. A header opens a fragment and is forwarded with `out_sof_o` set. Its bits 55:32 hold the trigger number, bits 31:20 the bunch-crossing number and bits 19:8 the source number.
- R4: A control word whose bits 63:60 equal 4'hA is a trailer. In an open fragment, the trailer is forwarded with `out_eof_o` set and closes the fragment. In the cycle after the trailer is read, `frag_done_o` pulses for one cycle. In that cycle the id outputs carry the fields of that fragment's header, and they hold until the next pulse.
- R5: Trailer bits 55:32 hold the fragment length in words, counting the header and the trailer. If this does not match the number of words forwarded for the fragment, `frag_len_err_o` is set with the done pulse.
- R6: The CRC is CRC-16 with polynomial 16'h1021 and seed 16'hFFFF. It is fed MSB first with the header, the payload words and the trailer with bits 31:16 forced to zero. If the result differs from trailer bits 31:16, `frag_crc_err_o` is set with the done pulse.
- R7: While no fragment is open, any word that is not a header is read, dropped and not forwarded, and `framing_err_o` pulses in the next cycle.
- R8: Inside an open fragment, a control word that is neither a header nor a trailer is dropped. It is not forwarded and not counted in the length or the CRC, and `framing_err_o` pulses.
- R9: A header that arrives while a fragment is open ends that fragment. The done pulse carries the old fragment's id with `frag_trl_err_o` set and the length and CRC flags clear. The new header then opens a new fragment.
- R10: After reset, `out_valid_o`, `frag_done_o`, `framing_err_o` and all error flags are low, and no fragment is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Receive FIFO has a word |
| in_ctrl_i | input | 1 | Word is a control word |
| in_data_i | input | 64 | Word from the receive FIFO |
| in_read_o | output | 1 | Pop the receive FIFO this cycle |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | DMA side takes the word |
| out_data_o | output | 64 | Forwarded word |
| out_sof_o | output | 1 | Word is a fragment header |
| out_eof_o | output | 1 | Word is a fragment trailer |
| frag_done_o | output | 1 | Fragment closed (one cycle) |
| frag_trig_o | output | 24 | Trigger number of the closed fragment |
| frag_bx_o | output | 12 | Bunch-crossing number of the closed fragment |
| frag_src_o | output | 12 | Source number of the closed fragment |
| frag_len_err_o | output | 1 | Length mismatch |
| frag_crc_err_o | output | 1 | CRC mismatch |
| frag_trl_err_o | output | 1 | Fragment closed by a new header, trailer missing |
| framing_err_o | output | 1 | A word was dropped for bad framing (one cycle) |

## Verification
The bench sends fragments of zero up to twenty payload words through the block while the DMA side stalls irregularly. A design that loaded a new word over a stalled one would lose or repeat words in the compared stream. Stray words are placed both before a header and inside a fragment. A design that forwarded them, or fed them into the count or the CRC, would turn good fragments into length or CRC failures. Deliberate length and CRC faults, a trailer with a nonzero status field, and a header that cuts a fragment short check three things: that each flag fires on its own, that only bits 31:16 are masked, and that a truncated fragment reports the old header's id with only the missing-trailer flag.

// File: rtl/frag_rx_pkg.sv
package frag_rx_pkg;
  localparam int WORD_W   = 64;
  localparam int MARK_LO  = 60;
  localparam int LENF_LO  = 32;
  localparam int LENF_W   = 24;
  localparam int CRCF_LO  = 16;
  localparam int CRC_W    = 16;
  localparam logic [3:0] HDR_MARK = 4'h5;
  localparam logic [3:0] TRL_MARK = 4'hA;

  typedef struct packed {
    logic [23:0] trig;
    logic [11:0] bx;
    logic [11:0] src;
  } frag_id_t;

  typedef enum logic {ST_IDLE, ST_OPEN} rx_state_e;
endpackage

// File: rtl/frag_crc16.sv
module frag_crc16 #(
  parameter int          DW   = 64,
  parameter int          CW   = 16,
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic [CW-1:0] crc_i,
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] crc_o
);
  logic [CW-1:0] c;
  logic          fb;

  // bit-serial update unrolled over the word, MSB first
  always_comb begin
    c  = crc_i;
    fb = 1'b0;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = c[CW-1] ^ data_i[i];
      c  = {c[CW-2:0], 1'b0};
      if (fb) c = c ^ POLY[CW-1:0];
    end
    crc_o = c;
  end
endmodule

// File: rtl/frag_rx_ctrl.sv
module frag_rx_ctrl
  import frag_rx_pkg::*;
#(
  parameter int          LEN_W    = 24,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_SEED = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              ctrl_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              fwd_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic              done_o,
  output frag_id_t          id_o,
  output logic              len_err_o,
  output logic              crc_err_o,
  output logic              trl_err_o,
  output logic              framing_o
);
  rx_state_e          state_q, state_d;
  logic [LEN_W-1:0]   cnt_q, cnt_d;
  logic [CRC_W-1:0]   crc_q, crc_d, crc_base, crc_nxt;
  frag_id_t           id_q, id_d, hdr_id;
  logic [WORD_W-1:0]  crc_word;
  logic               is_hdr, is_trl;
  logic               done_d, len_d, crce_d, trl_d, fr_d;
  logic [LEN_W-1:0]   len_rx;
  logic [CRC_W-1:0]   crc_rx;
  logic               unused_bits;

  assign is_hdr  = ctrl_i && (data_i[WORD_W-1:MARK_LO] == HDR_MARK);
  assign is_trl  = ctrl_i && (data_i[WORD_W-1:MARK_LO] == TRL_MARK);
  assign hdr_id  = '{trig: data_i[55:32], bx: data_i[31:20], src: data_i[19:8]};
  assign len_rx  = LEN_W'(data_i[LENF_LO+LENF_W-1:LENF_LO]);
  assign crc_rx  = data_i[CRCF_LO+CRC_W-1:CRCF_LO];
  assign unused_bits = ^{data_i[59:56], data_i[7:0]};

  always_comb begin
    crc_word = data_i;
    if (is_trl) crc_word[CRCF_LO+CRC_W-1:CRCF_LO] = '0;
  end
  assign crc_base = is_hdr ? CRC_SEED : crc_q;

  frag_crc16 #(.DW(WORD_W), .CW(CRC_W), .POLY(CRC_POLY)) u_crc (
    .crc_i (crc_base),
    .data_i(crc_word),
    .crc_o (crc_nxt)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    crc_d   = crc_q;
    id_d    = id_q;
    fwd_o   = 1'b0;
    sof_o   = 1'b0;
    eof_o   = 1'b0;
    done_d  = 1'b0;
    len_d   = 1'b0;
    crce_d  = 1'b0;
    trl_d   = 1'b0;
    fr_d    = 1'b0;
    if (take_i) begin
      unique case (state_q)
        ST_IDLE: begin
          if (is_hdr) begin
            fwd_o   = 1'b1;
            sof_o   = 1'b1;
            state_d = ST_OPEN;
            cnt_d   = LEN_W'(1);
            crc_d   = crc_nxt;
            id_d    = hdr_id;
          end else begin
            fr_d = 1'b1;
          end
        end
        ST_OPEN: begin
          if (is_hdr) begin
            // previous fragment lost its trailer
            fwd_o  = 1'b1;
            sof_o  = 1'b1;
            done_d = 1'b1;
            trl_d  = 1'b1;
            cnt_d  = LEN_W'(1);
            crc_d  = crc_nxt;
            id_d   = hdr_id;
          end else if (is_trl) begin
            fwd_o   = 1'b1;
            eof_o   = 1'b1;
            done_d  = 1'b1;
            len_d   = (cnt_q + LEN_W'(1)) != len_rx;
            crce_d  = crc_nxt != crc_rx;
            state_d = ST_IDLE;
          end else if (ctrl_i) begin
            fr_d = 1'b1;
          end else begin
            fwd_o = 1'b1;
            cnt_d = cnt_q + LEN_W'(1);
            crc_d = crc_nxt;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      crc_q     <= CRC_SEED;
      id_q      <= '0;
      id_o      <= '0;
      done_o    <= 1'b0;
      len_err_o <= 1'b0;
      crc_err_o <= 1'b0;
      trl_err_o <= 1'b0;
      framing_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      crc_q     <= crc_d;
      id_q      <= id_d;
      done_o    <= done_d;
      framing_o <= fr_d;
      if (done_d) begin
        id_o      <= id_q;
        len_err_o <= len_d;
        crc_err_o <= crce_d;
        trl_err_o <= trl_d;
      end
    end
  end

  a_r9_trl_err_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && trl_err_o) |-> (!len_err_o && !crc_err_o));
  a_r8_framing_not_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    framing_o |-> !done_o);
  a_r5_open_counts_header: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPEN) |-> (cnt_q != '0));
  a_r4_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !trl_err_o) |=> !done_o || trl_err_o || !$past(take_i));
endmodule

// File: rtl/frag_rx.sv
module frag_rx
  import frag_rx_pkg::*;
#(
  parameter int          LEN_W    = 24,
  parameter logic [15:0] CRC_POLY = 16'h1021,
  parameter logic [15:0] CRC_SEED = 16'hFFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic        in_ctrl_i,
  input  logic [63:0] in_data_i,
  output logic        in_read_o,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [63:0] out_data_o,
  output logic        out_sof_o,
  output logic        out_eof_o,
  output logic        frag_done_o,
  output logic [23:0] frag_trig_o,
  output logic [11:0] frag_bx_o,
  output logic [11:0] frag_src_o,
  output logic        frag_len_err_o,
  output logic        frag_crc_err_o,
  output logic        frag_trl_err_o,
  output logic        framing_err_o
);
  logic     fwd, sof, eof;
  frag_id_t id;

  // pop only when the single output slot can take the word
  assign in_read_o = in_valid_i && (!out_valid_o || out_ready_i);

  frag_rx_ctrl #(.LEN_W(LEN_W), .CRC_POLY(CRC_POLY), .CRC_SEED(CRC_SEED)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (in_read_o),
    .ctrl_i   (in_ctrl_i),
    .data_i   (in_data_i),
    .fwd_o    (fwd),
    .sof_o    (sof),
    .eof_o    (eof),
    .done_o   (frag_done_o),
    .id_o     (id),
    .len_err_o(frag_len_err_o),
    .crc_err_o(frag_crc_err_o),
    .trl_err_o(frag_trl_err_o),
    .framing_o(framing_err_o)
  );

  assign frag_trig_o = id.trig;
  assign frag_bx_o   = id.bx;
  assign frag_src_o  = id.src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_sof_o   <= 1'b0;
      out_eof_o   <= 1'b0;
    end else if (in_read_o && fwd) begin
      out_valid_o <= 1'b1;
      out_data_o  <= in_data_i;
      out_sof_o   <= sof;
      out_eof_o   <= eof;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  a_r2_hold_while_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)
                                       && $stable(out_sof_o) && $stable(out_eof_o)));
  a_r1_no_read_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_read_o);
  a_r3_sof_eof_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !(out_sof_o && out_eof_o));
  a_r4_eof_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frag_done_o && !frag_trl_err_o) |-> (out_valid_o && out_eof_o));
  a_r9_sof_with_trl_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frag_done_o && frag_trl_err_o) |-> (out_valid_o && out_sof_o));
endmodule

// File: tb/frag_rx_tb.sv
module frag_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ctrl = 1'b0, out_ready = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_read, out_valid, out_sof, out_eof;
  logic [63:0] out_data;
  logic        done, len_err, crc_err, trl_err, fr_err;
  logic [23:0] trig;
  logic [11:0] bx, src;

  always #4 clk = ~clk;

  frag_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ctrl_i(in_ctrl),
    .in_data_i(in_data), .in_read_o(in_read), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_data_o(out_data), .out_sof_o(out_sof),
    .out_eof_o(out_eof), .frag_done_o(done), .frag_trig_o(trig), .frag_bx_o(bx),
    .frag_src_o(src), .frag_len_err_o(len_err), .frag_crc_err_o(crc_err),
    .frag_trl_err_o(trl_err), .framing_err_o(fr_err)
  );

  int tests = 0, fails = 0;
  logic        st_c [0:1023];
  logic [63:0] st_d [0:1023];
  int          n_st = 0;
  logic [63:0] ex_d [0:1023];
  logic [1:0]  ex_m [0:1023];
  int          n_ex = 0;
  logic [50:0] ex_done [0:127];
  int          n_exd = 0, exp_fr = 0;
  int          got_out = 0, got_done = 0, got_fr = 0;
  bit          pend = 0;
  logic [47:0] pend_id;
  bit          active = 0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_w(logic [15:0] c, logic [63:0] d);
    logic [15:0] r = c;
    for (int i = 63; i >= 0; i--) begin
      logic f = r[15] ^ d[i];
      r = {r[14:0], 1'b0};
      if (f) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic put(bit c, logic [63:0] d);
    st_c[n_st] = c; st_d[n_st] = d; n_st++;
  endtask
  task automatic expo(logic [63:0] d, bit s, bit e);
    ex_d[n_ex] = d; ex_m[n_ex] = {s, e}; n_ex++;
  endtask

  task automatic frag(logic [23:0] t, logic [11:0] b, logic [11:0] s, int nd,
                      int ld, bit cf, bit close, int stray);
    logic [63:0] h, w, tl;
    logic [15:0] c;
    if (pend) begin
      ex_done[n_exd] = {3'b100, pend_id}; n_exd++; pend = 0;
    end
    h = {4'h5, 4'h0, t, b, s, 8'h00};
    put(1, h); expo(h, 1, 0); c = crc_w(16'hFFFF, h);
    for (int k = 0; k < nd; k++) begin
      if (k == stray) begin
        put(1, {4'hC, 60'h0123_4567_89AB_CDE}); exp_fr++;
      end
      w = {32'(k * 32'h9E37_79B1) ^ {8'h0, t}, 32'(~(k + 32'(b)) * 32'h0101_0107)};
      put(0, w); expo(w, 0, 0); c = crc_w(c, w);
    end
    if (close) begin
      tl = {4'hA, 4'h0, 24'(nd + 2 + ld), 16'h0000, 16'h00C3};
      c = crc_w(c, tl);
      tl[31:16] = cf ? (c ^ 16'h0001) : c;
      put(1, tl); expo(tl, 0, 1);
      ex_done[n_exd] = {1'b0, cf, ld != 0, t, b, s}; n_exd++;
    end else begin
      pend = 1; pend_id = {t, b, s};
    end
  endtask

  // driver and monitor: drive at negedge, sample 3 ns later (1 ns before posedge)
  int          idx = 0, cyc = 0;
  logic [15:0] lf = 16'hACE1;
  bit          took = 0, prev_stall = 0;
  logic [63:0] prev_d;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (active) begin
        if (took) idx++;
        in_valid  = (idx < n_st) && (lf[3:2] != 2'b00 || cyc[7]);
        in_ctrl   = (idx < n_st) ? st_c[idx] : 1'b0;
        in_data   = (idx < n_st) ? st_d[idx] : 64'h0;
        out_ready = cyc[6] ? 1'b1 : (lf[0] | lf[5]);
        #3;
        took = in_valid && in_read;
        // R1 handshake rule
        check(in_read == (in_valid && (!out_valid || out_ready)), "R1", "in_read_o",
              64'(in_read), 64'(in_valid && (!out_valid || out_ready)));
        if (prev_stall)  // R2
          check(out_valid && out_data == prev_d, "R2", "held word", out_data, prev_d);
        prev_stall = out_valid && !out_ready;
        prev_d     = out_data;
        if (out_valid && out_ready) begin
          if (got_out < n_ex) begin
            check(out_data == ex_d[got_out], "R1 R8", "word", out_data, ex_d[got_out]);
            check(out_sof == ex_m[got_out][1], "R3", "sof", 64'(out_sof), 64'(ex_m[got_out][1]));
            check(out_eof == ex_m[got_out][0], "R4", "eof", 64'(out_eof), 64'(ex_m[got_out][0]));
          end else check(0, "R1", "extra word", out_data, 64'h0);
          got_out++;
        end
        if (done) begin
          if (got_done < n_exd) begin
            check({trig, bx, src} == ex_done[got_done][47:0], "R4", "fragment id",
                  64'({trig, bx, src}), 64'(ex_done[got_done][47:0]));
            check(len_err == ex_done[got_done][48], "R5", "len_err",
                  64'(len_err), 64'(ex_done[got_done][48]));
            check(crc_err == ex_done[got_done][49], "R6", "crc_err",
                  64'(crc_err), 64'(ex_done[got_done][49]));
            check(trl_err == ex_done[got_done][50], "R9", "trl_err",
                  64'(trl_err), 64'(ex_done[got_done][50]));
          end else check(0, "R4", "extra done", 64'(got_done), 64'(n_exd));
          got_done++;
        end
        if (fr_err) got_fr++;
      end
    end
  end

  task automatic run();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    // R10 reset state
    check(!out_valid && !done && !fr_err && !len_err && !crc_err && !trl_err, "R10",
          "reset outputs", 64'({out_valid, done, fr_err, len_err, crc_err, trl_err}), 64'h0);
    // build stimulus
    frag(24'h000001, 12'h010, 12'h02A, 0, 0, 0, 1, -1);
    frag(24'h000002, 12'hABC, 12'h3FF, 5, 0, 0, 1, -1);
    frag(24'h000003, 12'h001, 12'h011, 4, 1, 0, 1, -1);   // R5
    frag(24'h000004, 12'h002, 12'h012, 3, 0, 1, 1, -1);   // R6
    put(0, 64'hDEAD_BEEF_0000_0001); exp_fr++;            // R7 data while idle
    put(1, 64'h3000_0000_0000_0000); exp_fr++;            // R7 bad marker while idle
    frag(24'h000005, 12'h003, 12'h013, 4, 0, 0, 1, 2);    // R8 stray inside
    frag(24'hFFFFFF, 12'hFFF, 12'h001, 3, 0, 0, 0, -1);   // R9 no trailer
    frag(24'h000006, 12'h004, 12'h014, 2, 0, 0, 1, -1);
    for (int n = 0; n <= 20; n++)
      frag(24'(n * 977), 12'(n * 31), 12'(n + 100), n, (n % 7 == 3) ? -1 : 0,
           n % 5 == 4, n % 9 != 8, (n % 6 == 5) ? 1 : -1);
    if (pend) frag(24'h000007, 12'h005, 12'h015, 1, 0, 0, 1, -1);
    put(1, 64'hA000_0000_0000_0000); exp_fr++;            // R7 trailer while idle
    active = 1;
    while (idx < n_st || got_out < n_ex || got_done < n_exd) @(negedge clk);
    repeat (10) @(negedge clk);
    check(got_out == n_ex, "R1", "forwarded count", 64'(got_out), 64'(n_ex));
    check(got_done == n_exd, "R4", "done count", 64'(got_done), 64'(n_exd));
    check(got_fr == exp_fr, "R7 R8", "framing pulses", 64'(got_fr), 64'(exp_fr));
  endtask

  initial begin
    fork
      run();
      begin
        #(8 * 150000);
        check(0, "R1", "watchdog expired", 64'(idx), 64'(n_st));
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule